// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines and presents one interrupt output to a processor. Each line is latched into a request register, either on a rising edge or by following its level, as chosen per line in a trigger-select register. A mask register hides lines from the output, and an in-service register records which interrupts the processor is handling. Priority runs through a rotating base: the line at the base index is highest, and priority falls as the index counts upward modulo eight. The base moves under command or under automatic rotation.

Software reaches the block through a small synchronous register port. A write strobe or a read strobe is held for one clock, with a 2-bit address. The processor acknowledges with a one-cycle strobe and takes the vector from a combinational output during that cycle. The controller comes out of any initialisation write through a short sequence of configuration words. In single-controller mode that sequence skips the cascade word. Once running, it accepts end-of-interrupt, rotation, read-select and poll commands.

Top module: `pic_core`

## Requirements
- R1: For a line in edge mode (trigger-select bit 0), the request bit is set only when the line is 1 in a cycle after it was sampled 0 in the previous cycle. A line held high after its request was acknowledged raises no new request.
- R2: For a line in level mode (trigger-select bit 1), the request bit equals the level sampled at each clock edge. An acknowledge does not clear it.
- R3: `int_out` is high exactly when some unmasked request exists whose priority is strictly higher than that of every in-service bit. The line at index base has the highest priority, and priority falls as the index counts upward modulo 8.
- R4: A masked line still sets its request bit, which can be read back, but it neither raises `int_out` nor takes part in priority resolution.
- R5: An address-0 write with data bit 4 set does the following:
  - It clears the request, in-service and mask registers, the sampled-level history, the priority base, the vector base, the poll flag, the read select and the mode flags, so `int_out` is low in the next cycle.
  - It records bit 0 as "mode word follows" and bit 1 as "single controller".
  - It leaves the trigger-select register unchanged.
- R6: After R5, the next address-1 write sets the vector base to data AND 0xF8. In cascade mode one further address-1 word is taken and discarded. When a mode word follows, the next address-1 write sets auto-EOI from data bit 1. After the sequence, address-1 writes load the mask.
- R7: An address-0 write with bits 4 and 3 clear is a command, and data bits 7:5 give its code:
  - Code 1 clears the highest-priority in-service bit.
  - Code 5 does the same and then sets the base to that index+1.
  - Code 3 clears the in-service bit named by bits 2:0.
  - Code 7 clears that bit and sets the base to that index+1.
  - Code 6 sets the base to bits 2:0 plus 1.
  - Code 4 enables rotation in auto-EOI and code 0 disables it. All index arithmetic is modulo 8.
- R8: An acknowledge while `int_out` is high returns vector base OR the winning index. It sets that in-service bit unless auto-EOI is on. With auto-EOI and rotation on, it sets the base to index+1 instead. It clears the request bit only for an edge-mode line.
- R9: An acknowledge while `int_out` is low returns vector base OR 7 and changes no state.
- R10: An address-0 write with bit 4 clear and bit 3 set works as follows:
  - Bit 2 arms a poll.
  - When bit 1 is set, bit 0 chooses what address-0 reads return: 0 gives requests and 1 gives in-service.
  - Address-1 reads return the mask.
  - Addresses 2 and 3 read and write the trigger-select register (1 = level).
- R11: While a poll is armed, a read at address 0 or 1 returns the index that would win the interrupt, or 7 if there is none. It clears that index's request and in-service bits and disarms the poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid combinationally while bus_rd is high |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt to the processor |
| int_ack | input | 1 | Acknowledge strobe, one cycle |
| int_vector | output | 8 | Vector returned during the acknowledge cycle |

## Verification
The bench goes after the following corner cases:
- An edge-mode line held high after its acknowledge. A design that treats it as level would interrupt again forever.
- A level line that must survive the acknowledge but drop when the input falls.
- A request of lower priority waiting behind an in-service bit. A design that ignores the in-service comparison would nest interrupts wrongly.
- Base moves from codes 5, 6 and 7 and from auto-EOI rotation, followed by a contest whose winner differs from the fixed-priority answer.
- Poll and spurious acknowledge with nothing pending, which must yield index 7.
- Re-initialisation, which must keep the trigger-select register and must skip the cascade word in single mode. A wrong sequencer would load the mask with the mode word.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NUM_IRQ = 8;
    localparam int IDX_W   = $clog2(NUM_IRQ);
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int VB_W    = DATA_W - IDX_W;
    localparam int CMD_W   = 3;

    // data bit positions decoded by the command port
    localparam int B_INIT    = 4;
    localparam int B_OCW3    = 3;
    localparam int B_POLL    = 2;
    localparam int B_RSEL_EN = 1;
    localparam int B_RSEL    = 0;
    localparam int B_NEED4   = 0;
    localparam int B_SINGLE  = 1;
    localparam int B_AEOI    = 1;

    typedef enum logic [CMD_W-1:0] {
        CMD_ROT_OFF    = 3'd0,
        CMD_EOI_TOP    = 3'd1,
        CMD_NOP        = 3'd2,
        CMD_EOI_SEL    = 3'd3,
        CMD_ROT_ON     = 3'd4,
        CMD_EOI_TOP_RB = 3'd5,
        CMD_SET_BASE   = 3'd6,
        CMD_EOI_SEL_RB = 3'd7
    } pic_cmd_e;

    typedef enum logic [1:0] {
        STEP_RUN  = 2'd0,
        STEP_VEC  = 2'd1,
        STEP_CASC = 2'd2,
        STEP_MODE = 2'd3
    } init_step_e;

    typedef struct packed {
        logic [NUM_IRQ-1:0] irr;
        logic [NUM_IRQ-1:0] isr;
        logic [NUM_IRQ-1:0] imr;
        logic [NUM_IRQ-1:0] trig;
        logic [NUM_IRQ-1:0] last;
        logic [IDX_W-1:0]   base;
        logic [VB_W-1:0]    vbase;
        init_step_e         step;
        logic               need_mode;
        logic               single;
        logic               aeoi;
        logic               rot_aeoi;
        logic               rd_isr;
        logic               poll;
    } pic_state_t;

endpackage

// File: rtl/pic_req_sample.sv
module pic_req_sample #(
    parameter int N = 8
) (
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] last,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] irr_cur,
    output logic [N-1:0] irr_next
);

    for (genvar g = 0; g < N; g++) begin : g_line
        logic rise;
        assign rise        = lvl[g] & ~last[g];
        assign irr_next[g] = trig[g] ? lvl[g] : (irr_cur[g] | rise);
    end

endmodule

// File: rtl/pic_rot_prio.sv
module pic_rot_prio #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] base,
    output logic          found,
    output logic [IW-1:0] offset,
    output logic [IW-1:0] index
);

    logic [N-1:0] rot;

    // rot[k] is the line at distance k from the base
    for (genvar g = 0; g < N; g++) begin : g_rot
        logic [IW-1:0] pos;
        assign pos    = IW'(g) + base;
        assign rot[g] = req[pos];
    end

    always_comb begin
        found  = 1'b0;
        offset = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (rot[i]) begin
                found  = 1'b1;
                offset = IW'(i);
            end
        end
    end

    assign index = offset + base;

endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_IRQ-1:0] irq_in,
    output logic              int_out,
    input  logic              int_ack,
    output logic [DATA_W-1:0] int_vector
);

    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_NONE = '1;

    pic_state_t s_q, s_d;

    logic [NUM_IRQ-1:0] irr_sampled;
    logic               pend_found, svc_found;
    logic [IDX_W-1:0]   pend_off, pend_idx, svc_off, svc_idx;
    logic               active;
    logic [IDX_W-1:0]   win_idx;
    pic_cmd_e           cmd;
    logic [IDX_W-1:0]   sel_idx;

    pic_req_sample #(.N(NUM_IRQ)) u_sample (
        .lvl      (irq_in),
        .last     (s_q.last),
        .trig     (s_q.trig),
        .irr_cur  (s_q.irr),
        .irr_next (irr_sampled)
    );

    pic_rot_prio #(.N(NUM_IRQ), .IW(IDX_W)) u_pend (
        .req    (s_q.irr & ~s_q.imr),
        .base   (s_q.base),
        .found  (pend_found),
        .offset (pend_off),
        .index  (pend_idx)
    );

    pic_rot_prio #(.N(NUM_IRQ), .IW(IDX_W)) u_svc (
        .req    (s_q.isr),
        .base   (s_q.base),
        .found  (svc_found),
        .offset (svc_off),
        .index  (svc_idx)
    );

    assign active     = pend_found && (!svc_found || (pend_off < svc_off));
    assign win_idx    = active ? pend_idx : IDX_NONE;
    assign int_out    = active;
    assign int_vector = {s_q.vbase, win_idx};
    assign cmd        = pic_cmd_e'(bus_wdata[DATA_W-1 -: CMD_W]);
    assign sel_idx    = bus_wdata[IDX_W-1:0];

    always_comb begin
        if (bus_addr[1])
            bus_rdata = s_q.trig;
        else if (s_q.poll)
            bus_rdata = {{VB_W{1'b0}}, win_idx};
        else if (bus_addr[0])
            bus_rdata = s_q.imr;
        else
            bus_rdata = s_q.rd_isr ? s_q.isr : s_q.irr;
    end

    always_comb begin
        s_d      = s_q;
        s_d.irr  = irr_sampled;
        s_d.last = irq_in;

        // acknowledge
        if (int_ack && active) begin
            if (s_q.aeoi) begin
                if (s_q.rot_aeoi)
                    s_d.base = pend_idx + IDX_ONE;
            end else begin
                s_d.isr[pend_idx] = 1'b1;
            end
            if (!s_q.trig[pend_idx])
                s_d.irr[pend_idx] = 1'b0;
        end

        // register writes
        if (bus_wr) begin
            if (bus_addr[1]) begin
                s_d.trig = bus_wdata;
            end else if (!bus_addr[0]) begin
                if (bus_wdata[B_INIT]) begin
                    s_d.irr       = '0;
                    s_d.isr       = '0;
                    s_d.imr       = '0;
                    s_d.last      = '0;
                    s_d.base      = '0;
                    s_d.vbase     = '0;
                    s_d.aeoi      = 1'b0;
                    s_d.rot_aeoi  = 1'b0;
                    s_d.rd_isr    = 1'b0;
                    s_d.poll      = 1'b0;
                    s_d.need_mode = bus_wdata[B_NEED4];
                    s_d.single    = bus_wdata[B_SINGLE];
                    s_d.step      = STEP_VEC;
                end else if (bus_wdata[B_OCW3]) begin
                    if (bus_wdata[B_POLL])
                        s_d.poll = 1'b1;
                    if (bus_wdata[B_RSEL_EN])
                        s_d.rd_isr = bus_wdata[B_RSEL];
                end else begin
                    unique case (cmd)
                        CMD_ROT_OFF:    s_d.rot_aeoi = 1'b0;
                        CMD_ROT_ON:     s_d.rot_aeoi = 1'b1;
                        CMD_EOI_TOP, CMD_EOI_TOP_RB: begin
                            if (svc_found) begin
                                s_d.isr[svc_idx] = 1'b0;
                                if (cmd == CMD_EOI_TOP_RB)
                                    s_d.base = svc_idx + IDX_ONE;
                            end
                        end
                        CMD_EOI_SEL:    s_d.isr[sel_idx] = 1'b0;
                        CMD_EOI_SEL_RB: begin
                            s_d.isr[sel_idx] = 1'b0;
                            s_d.base         = sel_idx + IDX_ONE;
                        end
                        CMD_SET_BASE:   s_d.base = sel_idx + IDX_ONE;
                        default:        ;
                    endcase
                end
            end else begin
                unique case (s_q.step)
                    STEP_RUN:  s_d.imr = bus_wdata;
                    STEP_VEC: begin
                        s_d.vbase = bus_wdata[DATA_W-1:IDX_W];
                        if (!s_q.single)
                            s_d.step = STEP_CASC;
                        else
                            s_d.step = s_q.need_mode ? STEP_MODE : STEP_RUN;
                    end
                    STEP_CASC: s_d.step = s_q.need_mode ? STEP_MODE : STEP_RUN;
                    STEP_MODE: begin
                        s_d.aeoi = bus_wdata[B_AEOI];
                        s_d.step = STEP_RUN;
                    end
                    default:   s_d.step = STEP_RUN;
                endcase
            end
        end

        // poll read
        if (bus_rd && !bus_addr[1] && s_q.poll) begin
            s_d.poll = 1'b0;
            if (active) begin
                s_d.irr[pend_idx] = 1'b0;
                s_d.isr[pend_idx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    // init word leaves no request or service state and keeps trigger modes
    assert_init_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && bus_wdata[B_INIT])
        |=> (!int_out && s_q.isr == '0 && s_q.imr == '0));

    assert_init_keeps_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && bus_wdata[B_INIT])
        |=> (s_q.trig == $past(s_q.trig)));

    // output only when an unmasked request exists
    assert_out_needs_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((s_q.irr & ~s_q.imr) != '0));

    // the signalled index is pending, unmasked and not in service
    assert_winner_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (s_q.irr[int_vector[IDX_W-1:0]] && !s_q.imr[int_vector[IDX_W-1:0]]
                     && !s_q.isr[int_vector[IDX_W-1:0]]));

    assert_ack_sets_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out && !s_q.aeoi && !bus_wr && !bus_rd)
        |=> s_q.isr[$past(int_vector[IDX_W-1:0])]);

    assert_edge_ack_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out && !s_q.trig[int_vector[IDX_W-1:0]] && !bus_wr)
        |=> !s_q.irr[$past(int_vector[IDX_W-1:0])]);

    assert_spurious_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_out) |-> (int_vector[IDX_W-1:0] == IDX_NONE));

endmodule

// File: tb/tb_pic_core.sv
`timescale 1ns/1ps
module tb_pic_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic       int_out;
    logic       int_ack = 1'b0;
    logic [7:0] int_vector;

    always #10 clk = ~clk;

    pic_core dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .int_out(int_out), .int_ack(int_ack),
        .int_vector(int_vector)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    int m_irr, m_isr, m_imr, m_trig, m_last, m_base, m_vbase;
    int m_step, m_need, m_single, m_aeoi, m_rot, m_rdisr, m_poll;
    int c_out, c_vec, c_rd;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int prio_of(input int mask);
        for (int p = 0; p < 8; p++)
            if (((mask >> ((p + m_base) % 8)) & 1) != 0) return p;
        return 8;
    endfunction

    function automatic int cur_irq();
        int p, c;
        p = prio_of(m_irr & ~m_imr & 255);
        if (p == 8) return -1;
        c = prio_of(m_isr);
        if (p < c) return (p + m_base) % 8;
        return -1;
    endfunction

    function automatic int exp_rdata();
        int q;
        q = cur_irq();
        if (bus_addr >= 2) return m_trig;
        if (m_poll != 0) return (q >= 0) ? q : 7;
        if (bus_addr == 1) return m_imr;
        return (m_rdisr != 0) ? m_isr : m_irr;
    endfunction

    task automatic model_reset();
        m_irr = 0; m_isr = 0; m_imr = 0; m_trig = 0; m_last = 0; m_base = 0;
        m_vbase = 0; m_step = 0; m_need = 0; m_single = 0; m_aeoi = 0;
        m_rot = 0; m_rdisr = 0; m_poll = 0;
    endtask

    task automatic model_step();
        int q, sp, d, a, lv;
        q  = cur_irq();
        sp = prio_of(m_isr);
        d  = bus_wdata;
        a  = bus_addr;
        lv = irq_in;
        for (int i = 0; i < 8; i++) begin
            if (((m_trig >> i) & 1) != 0) begin
                if (((lv >> i) & 1) != 0) m_irr |= (1 << i);
                else m_irr &= ~(1 << i);
            end else if ((((lv >> i) & 1) != 0) && (((m_last >> i) & 1) == 0)) begin
                m_irr |= (1 << i);
            end
        end
        m_last = lv;
        if (int_ack && q >= 0) begin
            if (m_aeoi != 0) begin
                if (m_rot != 0) m_base = (q + 1) % 8;
            end else m_isr |= (1 << q);
            if (((m_trig >> q) & 1) == 0) m_irr &= ~(1 << q);
        end
        if (bus_wr) begin
            if (a >= 2) m_trig = d;
            else if (a == 0) begin
                if ((d & 16) != 0) begin
                    m_irr = 0; m_isr = 0; m_imr = 0; m_last = 0; m_base = 0;
                    m_vbase = 0; m_aeoi = 0; m_rot = 0; m_rdisr = 0; m_poll = 0;
                    m_need = d & 1; m_single = (d >> 1) & 1; m_step = 1;
                end else if ((d & 8) != 0) begin
                    if ((d & 4) != 0) m_poll = 1;
                    if ((d & 2) != 0) m_rdisr = d & 1;
                end else begin
                    case (d >> 5)
                        0: m_rot = 0;
                        4: m_rot = 1;
                        1, 5: if (sp != 8) begin
                            m_isr &= ~(1 << ((sp + m_base) % 8));
                            if ((d >> 5) == 5) m_base = ((sp + m_base) % 8 + 1) % 8;
                        end
                        3: m_isr &= ~(1 << (d & 7));
                        7: begin m_isr &= ~(1 << (d & 7)); m_base = ((d & 7) + 1) % 8; end
                        6: m_base = ((d & 7) + 1) % 8;
                        default: ;
                    endcase
                end
            end else begin
                case (m_step)
                    0: m_imr = d;
                    1: begin
                        m_vbase = d & 8'hF8;
                        if (m_single == 0) m_step = 2;
                        else m_step = (m_need != 0) ? 3 : 0;
                    end
                    2: m_step = (m_need != 0) ? 3 : 0;
                    default: begin m_aeoi = (d >> 1) & 1; m_step = 0; end
                endcase
            end
        end
        if (bus_rd && a < 2 && m_poll != 0) begin
            m_poll = 0;
            if (q >= 0) begin m_irr &= ~(1 << q); m_isr &= ~(1 << q); end
        end
    endtask

    // one cycle: inputs set by caller just after a falling edge
    task automatic tick();
        int q;
        #2;
        q = cur_irq();
        c_out = int_out; c_vec = int_vector; c_rd = bus_rdata;
        check("R3", "int_out", int_out, (q >= 0) ? 1 : 0);
        if (int_ack) check("R8", "int_vector", int_vector, m_vbase | ((q >= 0) ? q : 7));
        if (bus_rd) check("R10", "bus_rdata", bus_rdata, exp_rdata());
        @(posedge clk);
        model_step();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; int_ack = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(d); tick();
    endtask
    task automatic rd(input int a);
        bus_rd = 1'b1; bus_addr = 2'(a); tick();
    endtask
    task automatic ack();
        int_ack = 1'b1; tick();
    endtask
    task automatic idle();
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        check("R5", "reset int_out", c_out, 0);
        rd(0);
        check("R5", "reset requests", c_rd, 8'h00);

        // cascade mode with mode word
        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h00);
        rd(1);
        check("R6", "mask after sequence", c_rd, 8'h00);

        // edge line held high
        irq_in = 8'h08; idle();
        ack();
        check("R8", "vector line 3", c_vec, 8'h23);
        wr(0, 8'h20); idle();
        check("R1", "no re-request while held", c_out, 0);
        irq_in = 8'h00; idle();

        // in-service blocks lower priority
        irq_in = 8'h22; idle();
        ack();
        check("R3", "line 1 beats 5", c_vec, 8'h21);
        idle();
        check("R3", "line 5 waits", c_out, 0);
        wr(0, 8'h20); idle();
        check("R7", "line 5 after EOI", c_out, 1);
        ack();
        check("R8", "vector line 5", c_vec, 8'h25);
        irq_in = 8'h00;
        wr(0, 8'h20);

        // rotation
        wr(0, 8'hC2);
        irq_in = 8'h22; idle();
        ack();
        check("R7", "base 3 winner", c_vec, 8'h25);
        wr(0, 8'hE5); idle();
        ack();
        check("R7", "after specific rotate", c_vec, 8'h21);
        wr(0, 8'hA0);
        irq_in = 8'h00; idle();
        irq_in = 8'h03; idle();
        ack();
        check("R7", "base 2 picks line 0", c_vec, 8'h20);
        wr(0, 8'h20);
        ack();
        check("R8", "then line 1", c_vec, 8'h21);
        wr(0, 8'h20);
        irq_in = 8'h00;

        // mask
        wr(1, 8'h10);
        irq_in = 8'h10; idle(); idle();
        check("R4", "masked line silent", c_out, 0);
        wr(0, 8'h0A); rd(0);
        check("R4", "masked request latched", c_rd, 8'h10);
        rd(1);
        check("R10", "mask read", c_rd, 8'h10);
        wr(1, 8'h00); idle();
        check("R4", "unmasked raises", c_out, 1);
        ack();
        check("R8", "vector line 4", c_vec, 8'h24);
        wr(0, 8'h20);
        irq_in = 8'h00;

        // level line
        wr(2, 8'h04); rd(2);
        check("R10", "trigger select read", c_rd, 8'h04);
        irq_in = 8'h04; idle();
        ack();
        check("R8", "vector line 2", c_vec, 8'h22);
        rd(0);
        check("R2", "level request kept", c_rd, 8'h04);
        wr(0, 8'h0B); rd(0);
        check("R10", "in-service read", c_rd, 8'h04);
        wr(0, 8'h62); idle();
        check("R2", "level re-raises", c_out, 1);
        irq_in = 8'h00; idle(); idle();
        wr(0, 8'h0A); rd(0);
        check("R2", "level follows low", c_rd, 8'h00);

        // poll
        irq_in = 8'h40; idle();
        wr(0, 8'h0C); rd(0);
        check("R11", "poll index", c_rd, 8'h06);
        rd(0);
        check("R11", "poll cleared request", c_rd, 8'h00);
        wr(0, 8'h0C); rd(1);
        check("R11", "poll empty", c_rd, 8'h07);
        irq_in = 8'h00;

        // spurious
        ack();
        check("R9", "spurious vector", c_vec, 8'h27);
        wr(0, 8'h0B); rd(0);
        check("R9", "spurious no service", c_rd, 8'h00);

        // single mode with mode word and auto-EOI rotation
        wr(0, 8'h13); rd(2);
        check("R5", "trigger select kept", c_rd, 8'h04);
        wr(1, 8'h4D); wr(1, 8'h02); wr(1, 8'h00);
        wr(0, 8'h80);
        irq_in = 8'h40; idle();
        ack();
        check("R6", "vector base masked", c_vec, 8'h4E);
        wr(0, 8'h0B); rd(0);
        check("R8", "auto-EOI no service", c_rd, 8'h00);
        irq_in = 8'h41; idle();
        ack();
        check("R8", "rotated base picks 0", c_vec, 8'h48);

        // single mode without mode word
        wr(0, 8'h12);
        wr(1, 8'h88);
        check("R5", "init drops output", c_out, 0);
        wr(1, 8'h00);
        rd(1);
        check("R6", "second word became mask", c_rd, 8'h00);
        ack();
        check("R6", "single skips cascade", c_vec, 8'h88);

        // randomised traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int r, d;
            if ($urandom % 4 == 0) irq_in = 8'($urandom);
            r = $urandom % 10;
            if (r < 2) begin
                bus_addr = 2'($urandom);
                d = $urandom & 255;
                if (bus_addr == 0 && (d & 16) != 0 && ($urandom % 16) != 0) d &= ~16;
                bus_wdata = 8'(d);
                bus_wr = 1'b1;
            end else if (r < 4) begin
                bus_addr = 2'($urandom);
                bus_rd = 1'b1;
            end else if (r < 6) begin
                int_ack = 1'b1;
            end
            tick();
        end
        finish_run();
    end

endmodule